// File: doc/BRIEF.md
# SPI master frame timing engine

This block is the shift engine of a serial-port master for the SPI frame format. When a start pulse arrives it pulls an active-low frame line down and generates a serial clock from the system clock. It sends a parallel word out most significant bit first and samples the incoming line into a received word. Once the frame line returns high, it raises a one-cycle done strobe. The word length, the clock divider, the clock idle level (polarity) and the clock phase are all programmable. The block captures these settings when a frame starts and holds them until that frame ends.

The phase control moves the serial clock half a period against the frame window. With phase 0 the clock waits one full period after the frame falls and stops half a period before the frame rises. With phase 1 the lead is half a period and the tail is a full period. Whether polarity and phase match decides which clock edge launches transmit data and which edge samples receive data. An internal loopback path can feed the transmit bit back to the receiver.

A two-bit format select is present, but the engine runs frames only for code 00 (SPI). Any other code is reported as unsupported. In that case the polarity and phase inputs have no effect and start requests are refused, so loopback cannot be used with the Microwire code either.

Top module: `spi_frame_engine`

## Requirements
- R1: While no frame is in progress and the format is 00, the serial clock rests at the level of the polarity input (0 low, 1 high), the frame line is high, and done is low. After reset the frame line is high, done is low and the clock is low.
- R2: With any format code other than 00, unsupported_o is 1 and the serial clock rests low regardless of polarity and phase. A start pulse produces no frame and no done strobe.
- R3: With phase 0, the first clock edge comes 2·H system cycles after the frame falls, and the frame rises H cycles after the last clock edge. Here H is the half period.
- R4: With phase 1, the first clock edge comes H cycles after the frame falls, and the frame rises 2·H cycles after the last clock edge.
- R5: The half period H equals divider+1 system cycles. A frame of N bits carries exactly 2·N clock edges and keeps the frame line low for (2·N+2)·H cycles.
- R6: When polarity equals phase, data is sampled on the rising clock edge and the transmit line changes only on falling edges. When they differ, these two edges swap. The transmit bits go out most significant bit first, starting with bit N-1 of the transmit word.
- R7: The word length input gives N. Values below 4 act as 4, and values above 16 act as 16. Transmit bits at or above N are not sent. The received word holds the N sampled bits right-aligned, with the first bit sampled at position N-1 and zeros above.
- R8: Done is high for exactly one system cycle, starting one cycle after the frame line rises, and the received word is valid in that cycle.
- R9: A start pulse that arrives while a frame is in progress is ignored. The current frame keeps its timing and no second frame follows.
- R10: With loopback set and format 00, the receiver samples the transmit bit and the data input is ignored, so the received word equals the N transmitted bits. With any other format, including the Microwire code 10, a start with loopback set is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, one cycle |
| fmt_i | input | 2 | Frame format select; 00 is SPI |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Serial clock phase |
| loop_i | input | 1 | Feed transmit bit back to the receiver |
| word_len_i | input | 5 | Bits per frame (4 to 16) |
| div_i | input | 8 | Half period minus one, in system cycles |
| tx_word_i | input | 16 | Word to transmit, right-aligned |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| frame_n_o | output | 1 | Active-low frame |
| mosi_o | output | 1 | Serial data out |
| rx_word_o | output | 16 | Received word, right-aligned |
| done_o | output | 1 | One-cycle frame completion strobe |
| unsupported_o | output | 1 | Format select is not SPI |

## Verification
The bench uses the default parameters: a 16-bit maximum word, a 4-bit minimum and an 8-bit divider. Dividers of 0 to 3 keep frames short, while still separating the one-half-period and two-half-period lead and tail, and the full divider range is not needed to reach them. Word lengths of 4, 16 and values beyond both clamp limits cover every corner of the length logic. All four polarity and phase pairs are run against a modelled slave, which lets the bench check edge roles from the data itself.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;

  localparam logic [1:0] FMT_SPI = 2'b00;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq #(
  parameter int LEN_W = 5,
  parameter int HW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             cpha,
  input  logic [LEN_W-1:0] nbits,
  output logic             edge_en,
  output logic             lead,
  output logic             sample,
  output logic             shift,
  output logic             last
);
  logic [HW-1:0] half_q, half_d;
  logic [HW-1:0] k_next, off, j, two_n;
  logic          in_rgn;

  assign k_next = half_q + 1'b1;
  assign off    = cpha ? HW'(1) : HW'(2);
  assign j      = k_next - off;
  assign two_n  = HW'(nbits) << 1;
  assign last   = (half_q == two_n + HW'(1));
  assign in_rgn = (k_next >= off) && (j < two_n);

  assign edge_en = tick && in_rgn && !last;
  assign lead    = ~j[0];
  assign sample  = edge_en && (lead ^ cpha);
  assign shift   = edge_en && !(lead ^ cpha) && (j != '0);

  always_comb begin
    half_d = half_q;
    if (clear)     half_d = '0;
    else if (tick) half_d = last ? '0 : k_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= '0;
    else        half_q <= half_d;
  end
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int MAX_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAX_W-1:0] tx_word,
  input  logic [LEN_W-1:0] nbits,
  input  logic             shift,
  input  logic             sample,
  input  logic             rx_bit,
  output logic             mosi,
  output logic [MAX_W-1:0] rx_word
);
  logic [MAX_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [LEN_W-1:0] pad;

  assign pad     = LEN_W'(MAX_W) - nbits;
  assign mosi    = tx_q[MAX_W-1];
  assign rx_word = rx_q;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = tx_word << pad;
      rx_d = '0;
    end else begin
      if (shift)  tx_d = tx_q << 1;
      if (sample) rx_d = {rx_q[MAX_W-2:0], rx_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_frame_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int MIN_W = 4,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int HW    = $clog2(2 * MAX_W + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       fmt_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             loop_i,
  input  logic [LEN_W-1:0] word_len_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [MAX_W-1:0] tx_word_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             frame_n_o,
  output logic             mosi_o,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             done_o,
  output logic             unsupported_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  xfer_state_e      state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d, nbits_in;
  logic [DIV_W-1:0] div_q, div_d;
  logic             cpol_q, cpol_d, cpha_q, cpha_d, loop_q, loop_d;
  logic             sclk_q, sclk_d, frame_q, frame_d, done_q, done_d;
  logic             is_spi, idle_live, start_ok, tick;
  logic             edge_en, lead, sample, shift, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign is_spi        = (fmt_i == FMT_SPI);
  assign unsupported_o = !is_spi;
  assign idle_live     = is_spi ? cpol_i : 1'b0;
  assign start_ok      = (state_q == ST_IDLE) && start_i && is_spi;

  always_comb begin
    if (word_len_i < LEN_W'(MIN_W))      nbits_in = LEN_W'(MIN_W);
    else if (word_len_i > LEN_W'(MAX_W)) nbits_in = LEN_W'(MAX_W);
    else                                 nbits_in = word_len_i;
  end

  spi_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst_n(rst_core_n), .run(state_q == ST_XFER),
    .div(div_q), .tick(tick)
  );

  spi_edge_seq #(.LEN_W(LEN_W), .HW(HW)) seq_i (
    .clk(clk), .rst_n(rst_core_n), .clear(start_ok), .tick(tick),
    .cpha(cpha_q), .nbits(len_q), .edge_en(edge_en), .lead(lead),
    .sample(sample), .shift(shift), .last(last)
  );

  spi_shift_path #(.MAX_W(MAX_W), .LEN_W(LEN_W)) path_i (
    .clk(clk), .rst_n(rst_core_n), .load(start_ok), .tx_word(tx_word_i),
    .nbits(nbits_in), .shift(shift), .sample(sample),
    .rx_bit(loop_q ? mosi_o : miso_i), .mosi(mosi_o), .rx_word(rx_word_o)
  );

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    div_d   = div_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    loop_d  = loop_q;
    sclk_d  = sclk_q;
    frame_d = frame_q;
    done_d  = (state_q == ST_FIN);
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = idle_live;
        if (start_ok) begin
          state_d = ST_XFER;
          frame_d = 1'b0;
          len_d   = nbits_in;
          div_d   = div_i;
          cpol_d  = cpol_i;
          cpha_d  = cpha_i;
          loop_d  = loop_i;
        end
      end
      ST_XFER: begin
        if (edge_en) sclk_d = cpol_q ^ lead;
        if (tick && last) begin
          state_d = ST_FIN;
          frame_d = 1'b1;
        end
      end
      ST_FIN: begin
        sclk_d  = idle_live;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      len_q   <= LEN_W'(MIN_W);
      div_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      loop_q  <= 1'b0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      div_q   <= div_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      loop_q  <= loop_d;
      sclk_q  <= sclk_d;
      frame_q <= frame_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign frame_n_o = frame_q;
  assign done_o    = done_q;
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n_o,
  input logic       sclk_o,
  input logic       done_o,
  input logic       unsupported_o,
  input logic       cpol_i,
  input logic [1:0] fmt_i
);
  logic [2:0] age_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 1'b1;
  end
  assign armed = (age_q == 3'd7);

  // R1
  idle_clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(frame_n_o) && $past(frame_n_o, 2) &&
     ($past(cpol_i) == $past(cpol_i, 2)) && ($past(fmt_i) == $past(fmt_i, 2)))
    |-> $stable(sclk_o));

  // R2
  no_frame_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (unsupported_o && frame_n_o) |=> frame_n_o);

  // R8
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done_o |=> !done_o);

  // R8
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done_o |-> (frame_n_o && $past(frame_n_o) && !$past(frame_n_o, 2)));
endmodule

bind spi_frame_engine spi_frame_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n_o(frame_n_o), .sclk_o(sclk_o),
  .done_o(done_o), .unsupported_o(unsupported_o), .cpol_i(cpol_i), .fmt_i(fmt_i)
);

// File: tb/spi_frame_engine_tb_top.sv
`timescale 1ns/1ps
module spi_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, start_i, cpol_i, cpha_i, loop_i, miso_i;
  logic [1:0]  fmt_i;
  logic [4:0]  word_len_i;
  logic [7:0]  div_i;
  logic [15:0] tx_word_i;
  logic        sclk_o, frame_n_o, mosi_o, done_o, unsupported_o;
  logic [15:0] rx_word_o;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  spi_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .loop_i(loop_i), .word_len_i(word_len_i), .div_i(div_i),
    .tx_word_i(tx_word_i), .miso_i(miso_i), .sclk_o(sclk_o), .frame_n_o(frame_n_o),
    .mosi_o(mosi_o), .rx_word_o(rx_word_o), .done_o(done_o), .unsupported_o(unsupported_o)
  );

  // tx[47:32] slave[31:16] len[15:8] div[7:4] {cpol,cpha}[1:0]
  localparam int NVEC = 10;
  localparam logic [47:0] VEC [NVEC] = '{
    48'h00A5_003C_08_1_0, 48'h005A_00C3_08_0_1, 48'h0ABC_0123_0C_2_2,
    48'hF00D_BEEF_10_0_3, 48'hFFF9_0006_04_3_0, 48'h8001_7FFE_10_1_1,
    48'h0013_000A_05_0_3, 48'h0155_02AA_0A_1_2, 48'h0007_0009_02_0_0,
    48'h1234_4321_1F_0_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic run_frame(input logic [15:0] tx, input logic [15:0] slv, input int len,
                           input int div, input logic cpol, input logic cpha,
                           input logic loop, input int restart_t);
    int eff, h, fall_t, rise_t, done_t, first_e, second_e, last_e, edges, samples, mosi_bad, bad;
    logic [15:0] cap, rxv, mask, exp_rx;
    logic prev_s, prev_f, prev_m, done_seen;
    eff  = (len < 4) ? 4 : (len > 16) ? 16 : len;
    h    = div + 1;
    mask = 16'((32'h1 << eff) - 1);
    @(negedge clk);
    fmt_i = 2'b00; tx_word_i = tx; word_len_i = 5'(len); div_i = 8'(div);
    cpol_i = cpol; cpha_i = cpha; loop_i = loop; start_i = 1'b0;
    miso_i = slv[eff-1];
    repeat (3) @(negedge clk);
    chk("R1 idle clock level", 32'(sclk_o), 32'(cpol));
    chk("R1 idle frame high", 32'(frame_n_o), 32'd1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    fall_t = -1; rise_t = -1; done_t = -1; first_e = -1; second_e = -1; last_e = -1;
    edges = 0; samples = 0; mosi_bad = 0; cap = '0; rxv = '0; done_seen = 1'b0;
    prev_s = cpol; prev_f = 1'b1; prev_m = mosi_o;
    for (int t = 0; t < 3000 && !done_seen; t++) begin
      start_i = (t == restart_t);
      if (prev_f && !frame_n_o) fall_t = t;
      if (!prev_f && frame_n_o) rise_t = t;
      if (!frame_n_o && t > 0 && mosi_o !== prev_m)
        if (!(sclk_o !== prev_s && sclk_o !== (cpol == cpha))) mosi_bad++;
      if (sclk_o !== prev_s) begin
        edges++;
        if (edges == 1) first_e = t;
        if (edges == 2) second_e = t;
        last_e = t;
        if (sclk_o === (cpol == cpha)) begin
          cap = {cap[14:0], mosi_o};
          samples++;
          miso_i = (samples < eff) ? slv[eff-1-samples] : 1'b0;
        end
      end
      if (done_o) begin
        done_seen = 1'b1;
        done_t = t;
        rxv = rx_word_o;
      end
      prev_s = sclk_o; prev_f = frame_n_o; prev_m = mosi_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(cpha ? "R4 lead half period" : "R3 lead full period", 32'(first_e - fall_t), 32'((cpha ? 1 : 2) * h));
    chk(cpha ? "R4 tail full period" : "R3 tail half period", 32'(rise_t - last_e), 32'((cpha ? 2 : 1) * h));
    chk("R5 edge count", 32'(edges), 32'(2 * eff));
    chk("R5 half period", 32'(second_e - first_e), 32'(h));
    chk("R5 frame length", 32'(rise_t - fall_t), 32'((2 * eff + 2) * h));
    chk("R6 slave captured msb first", 32'(cap & mask), 32'(tx & mask));
    chk("R6 mosi only on launch edges", 32'(mosi_bad), 32'd0);
    exp_rx = loop ? (tx & mask) : (slv & mask);
    chk(loop ? "R10 loopback word" : "R7 received word", 32'(rxv), 32'(exp_rx));
    chk("R8 done one cycle after frame", 32'(done_t - rise_t), 32'd1);
    chk("R8 done single cycle", 32'(done_o), 32'd0);
    if (restart_t >= 0) begin
      bad = 0;
      repeat (40) begin
        if (!frame_n_o || done_o) bad++;
        @(negedge clk);
      end
      chk("R9 no second frame", 32'(bad), 32'd0);
    end
  endtask

  task automatic run_refused(input logic [1:0] fmt, input logic loop, input string req);
    int bad;
    @(negedge clk);
    fmt_i = fmt; cpol_i = 1'b1; cpha_i = 1'b1; loop_i = loop; word_len_i = 5'd8; div_i = 8'd0;
    repeat (3) @(negedge clk);
    chk({req, " unsupported flag"}, 32'(unsupported_o), 32'd1);
    chk({req, " polarity ignored"}, 32'(sclk_o), 32'd0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    bad = 0;
    repeat (40) begin
      if (!frame_n_o || done_o || sclk_o) bad++;
      @(negedge clk);
    end
    chk({req, " start refused"}, 32'(bad), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; fmt_i = 2'b00; cpol_i = 1'b0; cpha_i = 1'b0;
    loop_i = 1'b0; miso_i = 1'b0; word_len_i = 5'd8; div_i = '0; tx_word_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset frame high", 32'(frame_n_o), 32'd1);
    chk("R1 reset done low", 32'(done_o), 32'd0);
    chk("R1 reset clock low", 32'(sclk_o), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 post reset clock idle", 32'(sclk_o), 32'd0);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][47:32], VEC[v][31:16], int'(VEC[v][15:8]), int'(VEC[v][7:4]),
                VEC[v][1], VEC[v][0], 1'b0, -1);

    // R9: restart pulse in mid-frame
    run_frame(16'h00C6, 16'h0039, 8, 1, 1'b0, 1'b1, 1'b0, 7);
    // R10: loopback with a conflicting slave word
    run_frame(16'h2D4B, 16'hD2B4, 16, 0, 1'b1, 1'b0, 1'b1, -1);
    // R2: unsupported format; R10: Microwire code with loopback refused
    run_refused(2'b01, 1'b0, "R2");
    run_refused(2'b10, 1'b1, "R10 R2");

    @(negedge clk);
    fmt_i = 2'b00; cpol_i = 1'b1; loop_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle level follows polarity", 32'(sclk_o), 32'd1);
    chk("R2 unsupported cleared", 32'(unsupported_o), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule